// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block sits between a CAN protocol engine and the transceiver pins. It holds a two-bit operating mode and steers the transmit and receive paths according to that mode. Three modes are supported: ordinary operation, listen-only bus monitoring, and self-test with an internal loopback. The protocol engine is outside this block. It is represented here only by a handful of ports: its transmit bit, its receive bit, a transmit-request line and a strobe that marks the ACK bit time.

Software may change the mode only while the engine is held in reset. The reserved code is rejected and recorded in a sticky error flag, which software can clear. In monitoring mode the block keeps the transmit pin recessive and presents every ACK slot to the engine as dominant. It also blocks transmit requests and reports each new one on a one-cycle illegal-request pulse. In self-test mode the engine's transmit bit is fed straight back to its receive input, and the external pin stays recessive.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset the mode is 00 (normal). The configuration read value, `modeErr` and `illegalReq` are all 0.
- R2: A write with `engInReset`=1 loads `cfgWrData[1:0]` into the mode when that value is 00, 01 or 10. The new mode is visible on `modeOut` in the cycle after the write edge. `cfgRdData` returns the mode in bits [1:0], and its upper bits read as 0 whatever was written.
- R3: A write while `engInReset`=0 leaves the mode unchanged.
- R4: A write of 11 while `engInReset`=1 keeps the previous mode and sets `modeErr` from the next cycle on. `modeErr` stays set until a cycle with `errClr`=1 and no new reserved write; a reserved write in the same cycle as `errClr` wins.
- R5: In mode 00, `canTxPin` equals `engTx`, `engRx` equals `canRxPin` (also during `ackSlot`), and `txReqOut` equals `txReqIn`.
- R6: In mode 01 (monitoring), `canTxPin` is 1 and `txReqOut` is 0 whatever the engine drives.
- R7: In mode 01, `engRx` is 0 while `ackSlot`=1 and equals `canRxPin` otherwise.
- R8: In mode 01, a rising edge of `txReqIn` makes `illegalReq` 1 for exactly the following cycle. `illegalReq` is 0 in every other case.
- R9: In mode 10 (self-test), `engRx` equals `engTx`, `canTxPin` is 1 and `txReqOut` equals `txReqIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| engInReset | input | 1 | Engine is held in reset; mode writes are allowed |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration write data; bits [1:0] are the mode |
| cfgRdData | output | 8 | Configuration read data |
| errClr | input | 1 | Clears the sticky reserved-write error |
| modeErr | output | 1 | Sticky flag: a reserved mode value was written |
| modeOut | output | 2 | Current operating mode |
| txReqIn | input | 1 | Transmit request from software |
| txReqOut | output | 1 | Transmit request passed to the engine |
| illegalReq | output | 1 | Pulse: transmit requested in monitoring mode |
| engTx | input | 1 | Engine transmit bit |
| engRx | output | 1 | Receive bit presented to the engine |
| ackSlot | input | 1 | Engine strobe marking the ACK bit time |
| canTxPin | output | 1 | Transmit pin to the transceiver |
| canRxPin | input | 1 | Receive pin from the transceiver |

## Verification
The bench targets the following corner cases:
- **Writes with the engine out of reset.** A gate that ignored `engInReset` would silently change the mode.
- **A reserved write followed by a clear, including a clear in the same cycle as a reserved write.** A faulty design would either lose the old mode or drop the error.
- **A recessive bus level during the ACK slot in monitoring mode.** Without the override the engine would see an unacknowledged frame. With the override leaking into normal mode, a real missing ACK would be masked.
- **A request held high across several cycles in monitoring mode.** A level-based pulse would fire repeatedly, and a leaky gate would pass the request to the engine.

In self-test mode the bench checks that the receive input follows the engine's own transmit bit and not the pin.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL = 2'b00,
    MODE_LISTEN = 2'b01,
    MODE_LOOP   = 2'b10,
    MODE_RSVD   = 2'b11
  } opMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loopRx;        // receive input fed from engine transmit
    logic holdRecessive; // transmit pin forced high
    logic ackForce;      // ACK slot presented as dominant
    logic blockTx;       // transmit request withheld from engine
  } pathCtl_t;

endpackage

// File: rtl/can_mode_ctl.sv
module can_mode_ctl
  import can_mode_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             engInReset,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             errClr,
  input  logic             txReqIn,
  output opMode_t          modeQ,
  output pathCtl_t         pathCtl,
  output logic             modeErr,
  output logic             illegalReq
);

  logic                wrGate;
  logic [MODE_W-1:0]   wrMode;
  logic                wrReserved;
  logic                txReqD;
  logic                isListen;

  assign wrMode     = cfgWrData[MODE_W-1:0];
  assign wrGate     = cfgWrEn && engInReset;
  assign wrReserved = wrGate && (wrMode == MODE_RSVD);
  assign isListen   = (modeQ == MODE_LISTEN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_NORMAL;
    end else if (wrGate && !wrReserved) begin
      modeQ <= opMode_t'(wrMode);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeErr <= 1'b0;
    end else if (wrReserved) begin
      modeErr <= 1'b1;
    end else if (errClr) begin
      modeErr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReqD     <= 1'b0;
      illegalReq <= 1'b0;
    end else begin
      txReqD     <= txReqIn;
      illegalReq <= isListen && txReqIn && !txReqD;
    end
  end

  always_comb begin
    pathCtl = '0;
    unique case (modeQ)
      MODE_LISTEN: begin
        pathCtl.holdRecessive = 1'b1;
        pathCtl.ackForce      = 1'b1;
        pathCtl.blockTx       = 1'b1;
      end
      MODE_LOOP: begin
        pathCtl.holdRecessive = 1'b1;
        pathCtl.loopRx        = 1'b1;
      end
      default: pathCtl = '0;
    endcase
  end

endmodule

// File: rtl/can_mode_path.sv
module can_mode_path
  import can_mode_pkg::*;
(
  input  pathCtl_t pathCtl,
  input  logic     engTx,
  input  logic     canRxPin,
  input  logic     ackSlot,
  input  logic     txReqIn,
  output logic     canTxPin,
  output logic     engRx,
  output logic     txReqOut
);

  always_comb begin
    canTxPin = pathCtl.holdRecessive ? 1'b1 : engTx;
    if (pathCtl.loopRx) begin
      engRx = engTx;
    end else if (pathCtl.ackForce && ackSlot) begin
      engRx = 1'b0;
    end else begin
      engRx = canRxPin;
    end
    txReqOut = txReqIn && !pathCtl.blockTx;
  end

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             engInReset,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  input  logic             errClr,
  output logic             modeErr,
  output logic [1:0]       modeOut,
  input  logic             txReqIn,
  output logic             txReqOut,
  output logic             illegalReq,
  input  logic             engTx,
  output logic             engRx,
  input  logic             ackSlot,
  output logic             canTxPin,
  input  logic             canRxPin
);

  localparam int PAD_W = CFG_W - MODE_W;

  opMode_t  modeQ;
  pathCtl_t pathCtl;

  can_mode_ctl #(.CFG_W(CFG_W)) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .engInReset (engInReset),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .errClr     (errClr),
    .txReqIn    (txReqIn),
    .modeQ      (modeQ),
    .pathCtl    (pathCtl),
    .modeErr    (modeErr),
    .illegalReq (illegalReq)
  );

  can_mode_path u_path (
    .pathCtl  (pathCtl),
    .engTx    (engTx),
    .canRxPin (canRxPin),
    .ackSlot  (ackSlot),
    .txReqIn  (txReqIn),
    .canTxPin (canTxPin),
    .engRx    (engRx),
    .txReqOut (txReqOut)
  );

  assign modeOut   = modeQ;
  assign cfgRdData = {{PAD_W{1'b0}}, modeQ};

endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk (
  input logic       clk,
  input logic       rstN,
  input logic       engInReset,
  input logic       cfgWrEn,
  input logic [1:0] wrMode,
  input logic       errClr,
  input logic       modeErr,
  input logic [1:0] modeOut,
  input logic       txReqIn,
  input logic       txReqOut,
  input logic       illegalReq,
  input logic       engTx,
  input logic       engRx,
  input logic       ackSlot,
  input logic       canTxPin,
  input logic       canRxPin
);

  // R3
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !engInReset |=> $stable(modeOut));

  // R4
  rsvd_never_loaded_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeOut != 2'b11);

  // R4
  rsvd_sets_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && engInReset && wrMode == 2'b11) |=> modeErr);

  // R6
  listen_pin_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b01) |-> (canTxPin && !txReqOut));

  // R7
  listen_ack_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b01 && ackSlot) |-> !engRx);

  // R8
  illegal_only_listen_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalReq |-> ($past(txReqIn) && $past(modeOut) == 2'b01));

  // R9
  loop_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b10) |-> (engRx == engTx && canTxPin));

  // R5
  normal_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut == 2'b00) |-> (canTxPin == engTx && engRx == canRxPin && txReqOut == txReqIn));

endmodule

bind can_mode_ctrl can_mode_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .engInReset (engInReset),
  .cfgWrEn    (cfgWrEn),
  .wrMode     (cfgWrData[1:0]),
  .errClr     (errClr),
  .modeErr    (modeErr),
  .modeOut    (modeOut),
  .txReqIn    (txReqIn),
  .txReqOut   (txReqOut),
  .illegalReq (illegalReq),
  .engTx      (engTx),
  .engRx      (engRx),
  .ackSlot    (ackSlot),
  .canTxPin   (canTxPin),
  .canRxPin   (canRxPin)
);

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       engInReset = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic       errClr = 1'b0;
  logic       modeErr;
  logic [1:0] modeOut;
  logic       txReqIn = 1'b0;
  logic       txReqOut;
  logic       illegalReq;
  logic       engTx = 1'b1;
  logic       engRx;
  logic       ackSlot = 1'b0;
  logic       canTxPin;
  logic       canRxPin = 1'b1;

  int nChecks = 0;
  int nFails  = 0;

  logic [1:0] mMode = 2'b00;
  logic       mErr  = 1'b0;
  logic       mPrevReq = 1'b0;
  logic       mIll  = 1'b0;

  always #5 clk = ~clk;

  can_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .engInReset(engInReset), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .errClr(errClr),
    .modeErr(modeErr), .modeOut(modeOut), .txReqIn(txReqIn),
    .txReqOut(txReqOut), .illegalReq(illegalReq), .engTx(engTx),
    .engRx(engRx), .ackSlot(ackSlot), .canTxPin(canTxPin), .canRxPin(canRxPin)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expTxPin(input logic [1:0] m, input logic tx);
    return (m == 2'b00) ? tx : 1'b1;
  endfunction

  function automatic logic expEngRx(input logic [1:0] m, input logic tx,
                                    input logic rx, input logic ack);
    if (m == 2'b10) return tx;
    if (m == 2'b01 && ack) return 1'b0;
    return rx;
  endfunction

  function automatic logic expReqOut(input logic [1:0] m, input logic req);
    return (m == 2'b01) ? 1'b0 : req;
  endfunction

  // compare all outputs with the model, then advance model through one edge
  task automatic stepCheck();
    #2;
    check("R2 modeOut", modeOut, mMode);
    check("R2 cfgRdData", cfgRdData, {6'b0, mMode});
    check("R4 modeErr", modeErr, mErr);
    check("R8 illegalReq", illegalReq, mIll);
    if (mMode == 2'b00) check("R5 txPin", canTxPin, expTxPin(mMode, engTx));
    else if (mMode == 2'b01) check("R6 txPin", canTxPin, expTxPin(mMode, engTx));
    else check("R9 txPin", canTxPin, expTxPin(mMode, engTx));
    if (mMode == 2'b01) check("R7 engRx", engRx, expEngRx(mMode, engTx, canRxPin, ackSlot));
    else if (mMode == 2'b10) check("R9 engRx", engRx, expEngRx(mMode, engTx, canRxPin, ackSlot));
    else check("R5 engRx", engRx, expEngRx(mMode, engTx, canRxPin, ackSlot));
    if (mMode == 2'b01) check("R6 txReqOut", txReqOut, expReqOut(mMode, txReqIn));
    else check("R5 txReqOut", txReqOut, expReqOut(mMode, txReqIn));
    @(posedge clk);
    mIll     = txReqIn && !mPrevReq && (mMode == 2'b01);
    mPrevReq = txReqIn;
    if (cfgWrEn && engInReset && cfgWrData[1:0] == 2'b11) mErr = 1'b1;
    else if (errClr) mErr = 1'b0;
    if (cfgWrEn && engInReset && cfgWrData[1:0] != 2'b11) mMode = cfgWrData[1:0];
    @(negedge clk);
  endtask

  task automatic drive(input logic rst, input logic wr, input logic [7:0] d,
                       input logic clr, input logic req, input logic tx,
                       input logic rx, input logic ack);
    engInReset = rst; cfgWrEn = wr; cfgWrData = d; errClr = clr;
    txReqIn = req; engTx = tx; canRxPin = rx; ackSlot = ack;
    stepCheck();
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    check("R1 mode", modeOut, 0);
    check("R1 rd", cfgRdData, 0);
    check("R1 err", modeErr, 0);
    check("R1 ill", illegalReq, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 write out of reset ignored
    drive(0, 1, 8'h01, 0, 0, 1, 1, 0);
    drive(0, 0, 8'h00, 0, 0, 1, 1, 0);
    check("R3 mode held", modeOut, 0);
    // R2 upper bits ignored, monitoring mode loaded
    drive(1, 1, 8'hFD, 0, 0, 1, 1, 0);
    drive(1, 0, 8'h00, 0, 0, 1, 1, 0);
    check("R2 rd upper zero", cfgRdData, 8'h01);
    // R7 recessive ACK presented as dominant
    drive(0, 0, 8'h00, 0, 0, 1, 1, 1);
    // R8 held request: single pulse
    drive(0, 0, 8'h00, 0, 1, 0, 1, 0);
    drive(0, 0, 8'h00, 0, 1, 0, 1, 0);
    drive(0, 0, 8'h00, 0, 1, 0, 1, 0);
    drive(0, 0, 8'h00, 0, 0, 1, 1, 0);
    // R4 reserved write keeps mode, sets error; clear with simultaneous reserved keeps it
    drive(1, 1, 8'h03, 0, 0, 1, 1, 0);
    drive(1, 1, 8'h03, 1, 0, 1, 1, 0);
    drive(1, 0, 8'h00, 0, 0, 1, 1, 0);
    check("R4 mode kept", modeOut, 1);
    drive(1, 0, 8'h00, 1, 0, 1, 1, 0);
    drive(1, 0, 8'h00, 0, 0, 1, 1, 0);
    check("R4 err cleared", modeErr, 0);
    // R9 loopback with pin at opposite level
    drive(1, 1, 8'h02, 0, 0, 1, 1, 0);
    drive(0, 0, 8'h00, 0, 1, 0, 1, 0);
    drive(0, 0, 8'h00, 0, 0, 1, 0, 1);
    // R5 back to normal, ACK recessive passes through
    drive(1, 1, 8'h00, 0, 0, 1, 1, 0);
    drive(0, 0, 8'h00, 0, 1, 0, 1, 1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      drive(1'($urandom % 4 == 0), 1'($urandom % 3 == 0), d,
            1'($urandom % 8 == 0), 1'($urandom % 3 == 0),
            1'($urandom), 1'($urandom), 1'($urandom % 4 == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule